// File: doc/BRIEF.md
# Float32 to Unsigned Integer Converter

This block turns an IEEE-754 single-precision operand into a 32-bit unsigned integer. Rounding follows a 2-bit rounding-mode input. It is not forced to truncate. The block reports an invalid flag, an inexact flag and a summary bit that is set when either flag is raised.

The rules for exceptional operands are strict. Any NaN gives zero. Every negative non-zero operand gives zero with invalid. The sign is tested before rounding, so a small negative fraction that would round to zero still counts as invalid. Positive values beyond the 32-bit range saturate. The invalid flag always masks the inexact flag.

A caller asserts `in_valid` together with the operand and the rounding mode. The result, the flags and `out_valid` appear on registered outputs one clock later. While `in_valid` is low, the registered result and flags hold their last values and `out_valid` reads 0.

Top module: `f2u_convert`

## Requirements
- R1: Any NaN operand (exponent field all ones, mantissa non-zero, either sign, quiet or signalling) gives result 0x00000000 with invalid=1 and inexact=0.
- R2: Any operand with sign bit 1 that is not a zero gives result 0 with invalid=1. This covers negative infinity, negative denormals and negative fractions of magnitude below one, in every rounding mode.
- R3: Whenever invalid is 1, inexact is reported as 0.
- R4: A positive operand whose rounded value exceeds 0xFFFFFFFF gives 0xFFFFFFFF with invalid=1. This includes positive infinity. 0x4F800000 (2^32) saturates, and 0x4F7FFFFF converts exactly to 0xFFFFFF00.
- R5: A positive operand is rounded by the mode `in_rmode`: 00 = nearest with ties to even, 01 = toward +infinity, 10 = toward -infinity, 11 = toward zero. For example, 1.5 gives 2/2/1/1 and 2.5 gives 2/3/2/2 in those four modes.
- R6: A positive in-range result that needed rounding raises inexact only. An exact integer raises no flag. +0 and -0 give 0 with no flag.
- R7: `out_flag_set` is 1 exactly when invalid or inexact is 1, and 0 when the conversion raised no flag.
- R8: Outputs are registered. `out_valid` equals `in_valid` of the previous cycle. A conversion accepted at one clock edge appears after that edge. When `in_valid` is 0, the result and flag outputs keep their previous values.
- R9: With `rst_n` low at a clock edge, all outputs are 0 after that edge.
- R10: A positive denormal is treated as a tiny positive value. It rounds to 0 with inexact, except under mode 01, where it gives 1 with inexact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_float | input | 32 | Single-precision operand |
| in_rmode | input | 2 | Rounding mode (00 nearest-even, 01 up, 10 down, 11 toward zero) |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | 32 | Unsigned integer result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_flag_set | output | 1 | Summary: any flag raised |

## Verification
The whole datapath is combinational between the input pins and a single output register bank. Every result, flag and `out_valid` is therefore due exactly one rising edge after the strobe. The bench drives each operand just after a falling edge and samples all outputs at the next falling edge, half a period after the capturing edge. The hold check drops `in_valid` for one cycle and presents a different operand. It then samples at the next falling edge, expecting `out_valid` low and the earlier result and flags unchanged. The reset check samples the same way after a reset edge that follows a non-zero conversion.

// File: rtl/f2u_pkg.sv
package f2u_pkg;

  localparam int FP_W  = 32;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int SIG_W = MAN_W + 1;
  localparam int INT_W = 32;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int UE_W  = EXP_W + 2;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_UP      = 2'b01,
    RM_DOWN    = 2'b10,
    RM_ZERO    = 2'b11
  } rmode_e;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] man;
  } fp_t;

  // mask of the n lowest significand bits
  function automatic logic [SIG_W-1:0] low_mask(input int n);
    logic [63:0] wide;
    wide = (64'd1 << n) - 64'd1;
    return wide[SIG_W-1:0];
  endfunction

  // decide whether the truncated magnitude moves up by one
  function automatic logic round_inc(input rmode_e rm, input logic sign,
                                     input logic lsb, input logic guard,
                                     input logic sticky);
    logic inc;
    case (rm)
      RM_NEAREST: inc = guard & (sticky | lsb);
      RM_UP:      inc = ~sign & (guard | sticky);
      RM_DOWN:    inc = sign & (guard | sticky);
      default:    inc = 1'b0;
    endcase
    return inc;
  endfunction

endpackage

// File: rtl/f2u_unpack.sv
module f2u_unpack
  import f2u_pkg::*;
(
  input  logic [FP_W-1:0]        fp_bits,
  output logic                   sign,
  output logic                   is_nan,
  output logic                   is_inf,
  output logic                   is_zero,
  output logic [SIG_W-1:0]       sig,
  output logic signed [UE_W-1:0] unb_exp
);
  fp_t  fp;
  logic exp_max;
  logic exp_min;
  logic man_nz;

  assign fp      = fp_t'(fp_bits);
  assign exp_max = &fp.expo;
  assign exp_min = ~|fp.expo;
  assign man_nz  = |fp.man;

  assign sign    = fp.sign;
  assign is_nan  = exp_max & man_nz;
  assign is_inf  = exp_max & ~man_nz;
  assign is_zero = exp_min & ~man_nz;

  // denormals carry no hidden one and use the minimum exponent
  assign sig     = {~exp_min, fp.man};
  assign unb_exp = exp_min ? UE_W'(1 - BIAS) : UE_W'(int'(fp.expo) - BIAS);
endmodule

// File: rtl/f2u_align.sv
module f2u_align
  import f2u_pkg::*;
(
  input  logic [SIG_W-1:0]       sig,
  input  logic signed [UE_W-1:0] unb_exp,
  output logic [INT_W-1:0]       mag,
  output logic                   guard,
  output logic                   sticky,
  output logic                   too_big
);
  always_comb begin
    int ue;
    int rsh;
    mag     = '0;
    guard   = 1'b0;
    sticky  = 1'b0;
    too_big = 1'b0;
    rsh     = 0;
    ue      = int'(unb_exp);
    if (ue >= INT_W) begin
      too_big = 1'b1;
    end else if (ue >= MAN_W) begin
      mag = INT_W'(sig) << (ue - MAN_W);
    end else if (ue >= 0) begin
      rsh    = MAN_W - ue;
      mag    = INT_W'(sig >> rsh);
      guard  = sig[rsh-1];
      sticky = |(sig & low_mask(rsh - 1));
    end else if (ue == -1) begin
      guard  = sig[SIG_W-1];
      sticky = |sig[SIG_W-2:0];
    end else begin
      sticky = |sig;
    end
  end
endmodule

// File: rtl/f2u_round.sv
module f2u_round
  import f2u_pkg::*;
(
  input  logic [INT_W-1:0] mag,
  input  logic             guard,
  input  logic             sticky,
  input  logic             sign,
  input  logic [1:0]       rmode,
  output logic [INT_W-1:0] rounded,
  output logic             carry,
  output logic             lost
);
  logic inc;

  assign lost = guard | sticky;
  assign inc  = round_inc(rmode_e'(rmode), sign, mag[0], guard, sticky);
  assign {carry, rounded} = {1'b0, mag} + (INT_W + 1)'(inc);
endmodule

// File: rtl/f2u_convert.sv
module f2u_convert
  import f2u_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [FP_W-1:0]  in_float,
  input  logic [1:0]       in_rmode,
  output logic             out_valid,
  output logic [INT_W-1:0] out_result,
  output logic             out_invalid,
  output logic             out_inexact,
  output logic             out_flag_set
);
  logic                   sign, is_nan, is_inf, is_zero;
  logic [SIG_W-1:0]       sig;
  logic signed [UE_W-1:0] unb_exp;
  logic [INT_W-1:0]       mag, rounded;
  logic                   guard, sticky, too_big, carry, lost;

  // named events for the checks
  logic                   neg_nonzero;
  logic                   pos_ovf;
  logic                   c_invalid;
  logic                   c_inexact;
  logic [INT_W-1:0]       c_result;

  f2u_unpack u_unpack (
    .fp_bits (in_float),
    .sign    (sign),
    .is_nan  (is_nan),
    .is_inf  (is_inf),
    .is_zero (is_zero),
    .sig     (sig),
    .unb_exp (unb_exp)
  );

  f2u_align u_align (
    .sig     (sig),
    .unb_exp (unb_exp),
    .mag     (mag),
    .guard   (guard),
    .sticky  (sticky),
    .too_big (too_big)
  );

  f2u_round u_round (
    .mag     (mag),
    .guard   (guard),
    .sticky  (sticky),
    .sign    (sign),
    .rmode   (in_rmode),
    .rounded (rounded),
    .carry   (carry),
    .lost    (lost)
  );

  // the sign is judged before rounding: a tiny negative value is still invalid
  assign neg_nonzero = sign & ~is_zero & ~is_nan;
  assign pos_ovf     = ~sign & ~is_nan & (too_big | carry);
  assign c_invalid   = is_nan | neg_nonzero | pos_ovf;
  assign c_inexact   = ~c_invalid & lost;
  assign c_result    = (is_nan | neg_nonzero) ? '0 :
                       pos_ovf                ? '1 : rounded;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_invalid  <= 1'b0;
      out_inexact  <= 1'b0;
      out_flag_set <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result   <= c_result;
        out_invalid  <= c_invalid;
        out_inexact  <= c_inexact;
        out_flag_set <= c_invalid | c_inexact;
      end
    end
  end

  // R1
  nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_nan |=> out_result == '0 && out_invalid && !out_inexact);

  // R2
  neg_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && sign && !is_zero |=> out_result == '0 && out_invalid);

  // R3
  inv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> !out_inexact);

  // R4
  inf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_inf && !sign |=> out_result == '1 && out_invalid);

  // R6
  exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !sign && !is_nan && !too_big && !guard && !sticky
    |=> !out_invalid && !out_inexact && !out_flag_set);

  // R7
  flag_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_flag_set == (out_invalid || out_inexact));

  // R8
  vld_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_result) && $stable(out_invalid));
endmodule

// File: tb/tb_f2u_convert.sv
`timescale 1ns/1ps
module tb_f2u_convert;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_float;
  logic [1:0]  in_rmode;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_invalid;
  logic        out_inexact;
  logic        out_flag_set;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  f2u_convert dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_float     (in_float),
    .in_rmode     (in_rmode),
    .out_valid    (out_valid),
    .out_result   (out_result),
    .out_invalid  (out_invalid),
    .out_inexact  (out_inexact),
    .out_flag_set (out_flag_set)
  );

  // {req, operand, mode, result, invalid, inexact}
  localparam int NV = 38;
  localparam logic [71:0] VEC [NV] = '{
    {4'd5,  32'h4EF32010, 2'd0, 32'h79900800, 1'b0, 1'b0}, // R5
    {4'd5,  32'h4C54FD44, 2'd0, 32'h0353F510, 1'b0, 1'b0}, // R5
    {4'd6,  32'h1733F6C2, 2'd0, 32'h00000000, 1'b0, 1'b1}, // R6
    {4'd6,  32'h2C9D9CDC, 2'd0, 32'h00000000, 1'b0, 1'b1}, // R6
    {4'd4,  32'h56EB7395, 2'd0, 32'hFFFFFFFF, 1'b1, 1'b0}, // R4
    {4'd1,  32'h7FC00000, 2'd0, 32'h00000000, 1'b1, 1'b0}, // R1
    {4'd1,  32'h7F800001, 2'd1, 32'h00000000, 1'b1, 1'b0}, // R1
    {4'd1,  32'hFFC00000, 2'd3, 32'h00000000, 1'b1, 1'b0}, // R1
    {4'd4,  32'h7F800000, 2'd0, 32'hFFFFFFFF, 1'b1, 1'b0}, // R4
    {4'd2,  32'hFF800000, 2'd0, 32'h00000000, 1'b1, 1'b0}, // R2
    {4'd6,  32'h00000000, 2'd0, 32'h00000000, 1'b0, 1'b0}, // R6
    {4'd6,  32'h80000000, 2'd1, 32'h00000000, 1'b0, 1'b0}, // R6
    {4'd2,  32'hBF000000, 2'd0, 32'h00000000, 1'b1, 1'b0}, // R2
    {4'd3,  32'hBF000000, 2'd3, 32'h00000000, 1'b1, 1'b0}, // R3
    {4'd2,  32'h80000001, 2'd1, 32'h00000000, 1'b1, 1'b0}, // R2
    {4'd2,  32'hC0200000, 2'd2, 32'h00000000, 1'b1, 1'b0}, // R2
    {4'd5,  32'h3FC00000, 2'd0, 32'h00000002, 1'b0, 1'b1}, // R5
    {4'd5,  32'h3FC00000, 2'd1, 32'h00000002, 1'b0, 1'b1}, // R5
    {4'd5,  32'h3FC00000, 2'd2, 32'h00000001, 1'b0, 1'b1}, // R5
    {4'd5,  32'h3FC00000, 2'd3, 32'h00000001, 1'b0, 1'b1}, // R5
    {4'd5,  32'h40200000, 2'd0, 32'h00000002, 1'b0, 1'b1}, // R5
    {4'd5,  32'h40200000, 2'd1, 32'h00000003, 1'b0, 1'b1}, // R5
    {4'd5,  32'h40200000, 2'd3, 32'h00000002, 1'b0, 1'b1}, // R5
    {4'd5,  32'h3F000000, 2'd0, 32'h00000000, 1'b0, 1'b1}, // R5
    {4'd5,  32'h3F000000, 2'd1, 32'h00000001, 1'b0, 1'b1}, // R5
    {4'd5,  32'h3F400000, 2'd0, 32'h00000001, 1'b0, 1'b1}, // R5
    {4'd5,  32'h3F400000, 2'd2, 32'h00000000, 1'b0, 1'b1}, // R5
    {4'd10, 32'h00000001, 2'd1, 32'h00000001, 1'b0, 1'b1}, // R10
    {4'd10, 32'h00000001, 2'd0, 32'h00000000, 1'b0, 1'b1}, // R10
    {4'd10, 32'h007FFFFF, 2'd3, 32'h00000000, 1'b0, 1'b1}, // R10
    {4'd4,  32'h4F7FFFFF, 2'd1, 32'hFFFFFF00, 1'b0, 1'b0}, // R4
    {4'd4,  32'h4F800000, 2'd3, 32'hFFFFFFFF, 1'b1, 1'b0}, // R4
    {4'd3,  32'h7F7FFFFF, 2'd1, 32'hFFFFFFFF, 1'b1, 1'b0}, // R3
    {4'd6,  32'h3F800000, 2'd0, 32'h00000001, 1'b0, 1'b0}, // R6
    {4'd6,  32'h4B000001, 2'd0, 32'h00800001, 1'b0, 1'b0}, // R6
    {4'd5,  32'h4AFFFFFF, 2'd0, 32'h00800000, 1'b0, 1'b1}, // R5
    {4'd5,  32'h4AFFFFFF, 2'd3, 32'h007FFFFF, 1'b0, 1'b1}, // R5
    {4'd5,  32'h4AFFFFFF, 2'd1, 32'h00800000, 1'b0, 1'b1}  // R5
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // drive after a falling edge, sample at the next falling edge
  task automatic apply(input logic [31:0] f, input logic [1:0] rm);
    in_valid = 1'b1;
    in_float = f;
    in_rmode = rm;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_float = 32'h0;
    in_rmode = 2'd0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", "out_valid",  32'(out_valid), 32'd0);
    check("R9", "out_result", out_result, 32'd0);
    check("R9", "flags", {29'd0, out_invalid, out_inexact, out_flag_set}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      logic [71:0] v;
      v   = VEC[i];
      tag = $sformatf("R%0d", v[71:68]);
      apply(v[67:36], v[35:34]);
      check("R8", "out_valid", 32'(out_valid), 32'd1);
      check(tag, $sformatf("result vec%0d", i), out_result, v[33:2]);
      check(tag, $sformatf("invalid vec%0d", i), 32'(out_invalid), 32'(v[1]));
      check(v[1] ? "R3" : tag, $sformatf("inexact vec%0d", i),
            32'(out_inexact), 32'(v[0]));
      check("R7", $sformatf("flag_set vec%0d", i), 32'(out_flag_set),
            32'(v[1] | v[0]));
    end

    // R8: hold while idle, with a new operand presented
    apply(32'h40200000, 2'd1);          // 3, inexact
    in_valid = 1'b0;
    in_float = 32'h7FC00000;
    in_rmode = 2'd0;
    @(negedge clk);
    check("R8", "idle out_valid", 32'(out_valid), 32'd0);
    check("R8", "idle result held", out_result, 32'd3);
    check("R8", "idle invalid held", 32'(out_invalid), 32'd0);
    check("R8", "idle inexact held", 32'(out_inexact), 32'd1);

    // R7: a flag-free conversion clears the summary bit after a flagged one
    apply(32'h7F800000, 2'd0);
    check("R7", "flag_set after inf", 32'(out_flag_set), 32'd1);
    apply(32'h41200000, 2'd0);          // 10.0 exact
    check("R7", "flag_set cleared", 32'(out_flag_set), 32'd0);
    check("R6", "10.0 result", out_result, 32'd10);

    // R9: reset after a non-zero result
    apply(32'h4EF32010, 2'd0);
    in_valid = 1'b0;
    rst_n    = 1'b0;
    @(negedge clk);
    check("R9", "reset result", out_result, 32'd0);
    check("R9", "reset flags", {30'd0, out_invalid, out_inexact}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    summary();
  end
endmodule